// File: doc/BRIEF.md
# Nibble-Bus Firmware Read Initiator

This block is the host end of a four-bit multiplexed bus that fetches single bytes from a firmware storage device. A requester gives it a 28-bit byte address and a 4-bit target ID. The controller then runs the whole bus cycle. It pulls the active-low frame strobe for the opening nibble and sends the target selector, the address and a size code. It then hands the bus over to the device through a two-cycle turnaround.

Once the device owns the bus, the controller polls its status nibble on every clock. A wait code may repeat any number of times, up to a limit set by software. A ready code means that the data follows. The byte arrives as two nibbles, low half first, and the controller puts it back together. After the device's own turnaround, the controller returns a one-cycle completion pulse that carries the byte. If the device waits too long, or sends a status code the controller does not know, the cycle ends with a one-cycle error pulse.

Top module: `nbus_rd_init`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R2: In the cycle after acceptance, `frame_n` is low and the bus carries 1101. In every other cycle `frame_n` is high.
- R3: The cycle after the start nibble carries the requested target ID.
- R4: The next seven cycles carry the 28-bit address, most significant nibble first.
- R5: Next comes a size nibble of 0000. Then the host drives 1111 for one cycle with `bus_oe` high, and then drops `bus_oe` for one cycle.
- R6: From the following cycle, `bus_in` is sampled on each rising edge. The value 0101 means wait and keeps the controller polling. The value 0000 means ready, and the first data nibble follows in the next cycle.
- R7: The data nibble sampled first forms `rd_data[3:0]`, and the nibble sampled second forms `rd_data[7:4]`.
- R8: Two device turnaround cycles with `bus_oe` low come after the data. Then `done` is high for exactly one cycle, with `rd_data` valid, and the controller is idle in the next cycle.
- R9: Let L be `wait_limit`, with 0 treated as 1. When the L-th consecutive wait code is sampled, `err` pulses for one cycle instead of `done`, and the controller returns to idle.
- R10: A status nibble that is neither 0101 nor 0000 ends the cycle with a one-cycle `err` pulse, and the controller returns to idle.
- R11: `bus_oe` is low in every cycle where the host does not drive a field: idle, the release cycle, status, data, device turnaround and the completion or error cycle.
- R12: A request presented while the controller is busy is ignored. The address and ID on the bus stay those of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 28 | Byte address of the read |
| req_id | input | 4 | Target device selector |
| wait_limit | input | 8 | Maximum wait codes tolerated (0 acts as 1) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle error pulse (timeout or bad status) |
| rd_data | output | 8 | Byte read, valid with `done` |
| bus_out | output | 4 | Nibble driven by the host |
| bus_oe | output | 1 | Host output enable for the bus |
| bus_in | input | 4 | Nibble seen on the bus |
| frame_n | output | 1 | Active-low frame strobe |

## Verification
The bench varies the number of wait codes from zero up to just below the limit and checks that data is still captured. A design that sampled the status nibble once, or that mistimed its wait count, would hang or lose the byte. It also sets the limit to exactly the number of waits and to zero, where an off-by-one timeout would either return data or fail one wait too late. Bytes with different upper and lower halves catch a swapped nibble order. An unknown status code catches a design that treats any non-wait value as ready. A request held high through a busy cycle catches a design that re-latches the address partway through.

// File: rtl/nbus_rd_init.sv
module nbus_rd_init #(
  parameter int AW = 28,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_id,
  input  logic [LW-1:0] wait_limit,
  output logic          done,
  output logic          err,
  output logic [7:0]    rd_data,
  output logic [3:0]    bus_out,
  output logic          bus_oe,
  input  logic [3:0]    bus_in,
  output logic          frame_n
);
  localparam int NIB = AW / 4;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_SEL, S_ADDR, S_SIZE, S_TAR0, S_TAR1,
    S_SYNC, S_DLO, S_DHI, S_RTAR0, S_RTAR1, S_DONE, S_FAIL
  } st_t;

  st_t          st;
  logic [AW-1:0] addr_q;
  logic [3:0]   id_q;
  logic [LW-1:0] cnt;
  logic [7:0]   data_q;
  logic [LW:0]  waits_next;

  assign waits_next = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      id_q   <= '0;
      cnt    <= '0;
      data_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          id_q   <= req_id;
          st     <= S_START;
        end
        S_START: st <= S_SEL;
        S_SEL: begin
          cnt <= '0;
          st  <= S_ADDR;
        end
        S_ADDR: begin
          addr_q <= addr_q << 4;
          cnt    <= cnt + 1'b1;
          if (cnt == LW'(NIB - 1)) st <= S_SIZE;
        end
        S_SIZE: st <= S_TAR0;
        S_TAR0: st <= S_TAR1;
        S_TAR1: begin
          cnt <= '0;
          st  <= S_SYNC;
        end
        S_SYNC: begin
          if (bus_in == 4'b0000) st <= S_DLO;
          else if (bus_in == 4'b0101) begin
            if (waits_next >= {1'b0, wait_limit}) st <= S_FAIL;
            else cnt <= cnt + 1'b1;
          end else st <= S_FAIL;
        end
        S_DLO: begin
          data_q[3:0] <= bus_in;
          st <= S_DHI;
        end
        S_DHI: begin
          data_q[7:4] <= bus_in;
          st <= S_RTAR0;
        end
        S_RTAR0: st <= S_RTAR1;
        S_RTAR1: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign frame_n   = (st != S_START);
  assign bus_oe    = (st == S_START) || (st == S_SEL) || (st == S_ADDR) ||
                     (st == S_SIZE) || (st == S_TAR0);
  assign done      = (st == S_DONE);
  assign err       = (st == S_FAIL);
  assign rd_data   = data_q;

  always_comb begin
    case (st)
      S_START: bus_out = 4'b1101;
      S_SEL:   bus_out = id_q;
      S_ADDR:  bus_out = addr_q[AW-1 -: 4];
      S_SIZE:  bus_out = 4'b0000;
      default: bus_out = 4'b1111;
    endcase
  end

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> (bus_oe && bus_out == 4'b1101)) else $error("frame");   // R2
  AST_ACCEPT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !frame_n) else $error("accept");       // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)) else $error("done pulse");           // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!err && req_ready)) else $error("err pulse");              // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)) else $error("done and err");                        // R10
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || done || err) |-> !bus_oe) else $error("oe");          // R11
endmodule

// File: tb/nbus_rd_init_tb.sv
module nbus_rd_init_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [27:0] req_addr = '0;
  logic [3:0]  req_id = '0;
  logic [7:0]  wait_limit = 8'd4;
  logic        done, err, bus_oe, frame_n;
  logic [7:0]  rd_data;
  logic [3:0]  bus_out;
  logic [3:0]  dev_bus = 4'hF;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  nbus_rd_init u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_id(req_id), .wait_limit(wait_limit),
    .done(done), .err(err), .rd_data(rd_data), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_in(dev_bus), .frame_n(frame_n)
  );

  // {addr[28], id[4], waits[8], data[8], limit[8], status code[4]}
  localparam int NV = 7;
  localparam logic [59:0] VEC [NV] = '{
    {28'h1234567, 4'h3, 8'd0, 8'hA5, 8'd4, 4'h0},
    {28'hFEDCBA9, 4'hF, 8'd2, 8'h3C, 8'd8, 4'h0},
    {28'h0000001, 4'h0, 8'd3, 8'hFF, 8'd4, 4'h0},
    {28'hABCDEF0, 4'h7, 8'd5, 8'h00, 8'd4, 4'h0},
    {28'h555AAAA, 4'h1, 8'd1, 8'h81, 8'd9, 4'h3},
    {28'h8000000, 4'h2, 8'd1, 8'h12, 8'd0, 4'h0},
    {28'h0F0F0F0, 4'hE, 8'd0, 8'h96, 8'd0, 4'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [59:0] v, input bit hold);
    logic [27:0] a;
    logic [3:0] id, code;
    logic [7:0] waits, dat, lim;
    int L;
    bit experr;
    string ereq;
    {a, id, waits, dat, lim, code} = v;
    L = (lim == 0) ? 1 : int'(lim);
    experr = (int'(waits) >= L) || (code != 4'h0);
    ereq = (int'(waits) >= L) ? "R9" : "R10";
    @(negedge clk);
    wait_limit = lim;
    check("R1 ready idle", req_ready, 1);
    check("R11 oe idle", bus_oe, 0);
    req_valid = 1; req_addr = a; req_id = id;
    @(negedge clk);
    if (hold) begin req_addr = ~a; req_id = ~id; end
    else req_valid = 0;
    check("R2 frame low", frame_n, 0);
    check("R2 start nibble", bus_out, 4'hD);
    check("R5 oe start", bus_oe, 1);
    @(negedge clk);
    check("R2 frame high", frame_n, 1);
    check("R3 id nibble", bus_out, id);
    check(hold ? "R12 busy ready" : "R1 busy ready", req_ready, 0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check(hold ? "R12 addr kept" : "R4 addr nibble", bus_out, a[27-4*i -: 4]);
    end
    @(negedge clk);
    check("R5 size", bus_out, 4'h0);
    @(negedge clk);
    check("R5 tar drive", {bus_oe, bus_out}, {1'b1, 4'hF});
    @(negedge clk);
    check("R5 tar release", bus_oe, 0);
    req_valid = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      check("R11 oe sync", bus_oe, 0);
      check("R6 polling", {done, err}, 0);
      dev_bus = (k < int'(waits)) ? 4'h5 : code;
      if (k < int'(waits) && k == L - 1) break;
      if (k >= int'(waits)) break;
    end
    if (experr) begin
      @(negedge clk);
      dev_bus = 4'hF;
      check({ereq, " err"}, {err, done}, 2'b10);
      check("R11 oe err", bus_oe, 0);
      @(negedge clk);
      check({ereq, " back idle"}, {err, req_ready}, 2'b01);
    end else begin
      @(negedge clk); dev_bus = dat[3:0];
      check("R6 after ready", {done, err, bus_oe}, 0);
      @(negedge clk); dev_bus = dat[7:4];
      @(negedge clk); dev_bus = 4'hF;
      check("R8 dev tar0", {bus_oe, done}, 0);
      @(negedge clk);
      check("R8 dev tar1", {bus_oe, done}, 0);
      @(negedge clk);
      check("R8 done", {done, err}, 2'b10);
      check("R7 data", rd_data, dat);
      check("R2 frame idle", frame_n, 1);
      @(negedge clk);
      check("R8 done one cycle", {done, req_ready}, 2'b01);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired in R1..R12 run: actual hang expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #5;
    check("R1 reset ready", req_ready, 1);
    check("R2 reset frame", frame_n, 1);
    check("R11 reset oe", bus_oe, 0);
    check("R8 reset done", {done, err}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NV; i++) run(VEC[i], 0);
    // R12: request held during a busy cycle
    run({28'h2468ACE, 4'h9, 8'd1, 8'h5A, 8'd3, 4'h0}, 1);
    // R10: all-ones status is not ready
    run({28'h1111111, 4'h4, 8'd0, 8'h77, 8'd4, 4'hF}, 0);
    // R9: waits equal to limit
    run({28'h7654321, 4'h6, 8'd3, 8'hC3, 8'd3, 4'h0}, 0);
    // R6: waits one below limit
    run({28'h7654321, 4'h6, 8'd2, 8'hC3, 8'd3, 4'h0}, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule